// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read

This block moves words from a write clock domain into an unrelated read clock domain through a small memory array. Each side keeps a binary pointer with one extra wrap bit. It publishes that pointer as Gray code, and the other side resynchronises it through two flip-flops. The write side reports whether a location is free. The read side drives an output data register and one status flag.

The read timing mode is taken from `fwft_i` while reset is held, and it stays fixed until the next reset.

- **Standard mode.** The read flag means "memory holds a word". A read strobe is needed to move that word into the output register.
- **Fall-through mode.** The read flag means "a fresh word is already in the output register". The first word moves there without a read strobe, and a read strobe consumes it.

The mode sets both what the flag means and how many read-clock edges pass before a written word becomes visible.

Top module: `dual_clock_fifo`

## Requirements
- R1: The mode is captured from `fwft_i` (1 = fall-through, 0 = standard) on read-clock edges while `rst_ni` is low. After reset, `wr_rdy_o` is 1, `rd_flag_o` is 0 and `rd_data_o` is 0.
- R2: In standard mode, a word written into an empty FIFO raises `rd_flag_o` after the second rising read-clock edge that follows the write edge. The flag is still 0 after the first such edge.
- R3: In standard mode, `rd_en_i` sampled high while `rd_flag_o` is 1 loads the oldest word into `rd_data_o` on that edge. `rd_en_i` while `rd_flag_o` is 0 leaves `rd_data_o` unchanged.
- R4: In fall-through mode, a word written into an empty FIFO appears on `rd_data_o` on the third rising read-clock edge after the write, with `rd_flag_o` rising on that same edge. Both are unchanged after the second edge.
- R5: In fall-through mode, the output word and the flag hold while `rd_en_i` is low. A read while the flag is 1 consumes the word and loads the next one on the same edge if memory holds one; otherwise the flag drops. A read while the flag is 0 changes nothing.
- R6: `wr_rdy_o` is 0 when the memory holds DEPTH words. A write attempted then is ignored and stores nothing.
- R7: After a read frees a location in a full FIFO, `wr_rdy_o` is still 0 after the first rising write-clock edge following the read edge, and is 1 after the second.
- R8: In both modes, words leave in the order they were accepted, without loss or duplication, under any mix of reads and writes on unrelated clocks.
- R9: Changing `fwft_i` outside reset has no effect on the read timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk_i | input | 1 | Write-side clock |
| rd_clk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| fwft_i | input | 1 | Mode select, sampled during reset: 1 fall-through, 0 standard |
| wr_en_i | input | 1 | Write strobe, wr_clk_i domain |
| wr_data_i | input | DW | Write data |
| wr_rdy_o | output | 1 | High when a location is free (full flag / input ready) |
| rd_en_i | input | 1 | Read strobe, rd_clk_i domain |
| rd_data_o | output | DW | Output data register |
| rd_flag_o | output | 1 | Empty flag (standard) or output-ready flag (fall-through) |

## Verification
**Latency windows.** A write edge should be seen by the read side after two read-clock edges in standard mode and after three in fall-through mode. A read edge should release the write flag after two write-clock edges.

**How the bench measures them.** The bench counts clock edges of each domain and records the other domain's count at every strobe edge. It samples the flag on the falling edge after each counted rising edge, and checks it is still low one edge before its release and high exactly at its release.

**Clock choice.** The two clock periods are chosen so their rising edges never coincide, which makes "the first edge after" unambiguous.

**Random traffic.** Words read under random traffic are compared with a reference queue. In standard mode the comparison is made one read-clock edge after the read strobe. In fall-through mode it is made while the word is presented, before it is consumed.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    typedef enum logic {
        RD_STD  = 1'b0,
        RD_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DW = 36,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = gray_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Gray to binary: each bit folds in every higher Gray bit
    always_comb begin
        bin_o[W-1] = st_q.s2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_o[i] = bin_o[i+1] ^ st_q.s2[i];
        end
    end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [AW:0]   rbin_sync_i,
    output logic          push_o,
    output logic [AW-1:0] waddr_o,
    output logic [AW:0]   wgray_o,
    output logic          wr_rdy_o
);
    localparam int          PW       = AW + 1;
    localparam logic [AW:0] FULL_LVL = {1'b1, {AW{1'b0}}};

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [PW-1:0] level;
    logic          full;
    logic          push;

    always_comb begin
        level   = st_q.bin - rbin_sync_i;
        full    = (level == FULL_LVL);
        push    = wr_en_i && !full;
        st_d.bin  = st_q.bin + PW'(push);
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push_o   = push;
    assign waddr_o  = st_q.bin[AW-1:0];
    assign wgray_o  = st_q.gray;
    assign wr_rdy_o = !full;

    // R6: a refused write leaves the write pointer where it was
    a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_rdy_o) |=> (st_q.bin == $past(st_q.bin)));

    // R6: the fill level seen by the write side never exceeds the depth
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);

    // R8: the published pointer changes by at most one Gray bit per edge
    a_r8_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.gray ^ $past(st_q.gray)));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_i,
    input  logic          rd_en_i,
    input  logic [AW:0]   wbin_sync_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [AW-1:0] raddr_o,
    output logic [AW:0]   rgray_o,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_flag_o
);
    localparam int          PW    = AW + 1;
    localparam logic [AW:0] DEPTH = {1'b1, {AW{1'b0}}};

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [DW-1:0] dout;
        logic          oreg_full;
    } rd_state_t;

    rd_state_t st_d, st_q;
    rd_mode_e  mode_q;
    logic      avail;
    logic      load;
    logic      flag;

    // Mode is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= rd_mode_e'(fwft_i);
    end

    always_comb begin
        st_d  = st_q;
        avail = (wbin_sync_i != st_q.bin);
        if (mode_q == RD_FWFT) begin
            load = avail && (!st_q.oreg_full || rd_en_i);
            flag = st_q.oreg_full;
            if (load)         st_d.oreg_full = 1'b1;
            else if (rd_en_i) st_d.oreg_full = 1'b0;
        end else begin
            load           = rd_en_i && avail;
            flag           = avail;
            st_d.oreg_full = 1'b0;
        end
        if (load) begin
            st_d.dout = mem_rdata_i;
            st_d.bin  = st_q.bin + PW'(1);
        end
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr_o   = st_q.bin[AW-1:0];
    assign rgray_o   = st_q.gray;
    assign rd_data_o = st_q.dout;
    assign rd_flag_o = flag;

    // R3: in standard mode a read against a low flag leaves the output alone
    a_r3_std_ignore_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RD_STD && rd_en_i && !rd_flag_o) |=> $stable(rd_data_o));

    // R5: in fall-through mode a presented word waits for its read
    a_r5_fwft_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RD_FWFT && rd_flag_o && !rd_en_i) |=> ($stable(rd_data_o) && rd_flag_o));

    // R8: the read pointer never overtakes the write pointer it has seen
    a_r8_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin_sync_i - st_q.bin) <= DEPTH);

    // R8: the published read pointer moves one Gray bit at a time
    a_r8_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.gray ^ $past(st_q.gray)));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 36
) (
    input  logic          wr_clk_i,
    input  logic          rd_clk_i,
    input  logic          rst_ni,
    input  logic          fwft_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          wr_rdy_o,
    input  logic          rd_en_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_flag_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          push;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wbin_in_rd;
    logic [PW-1:0] rbin_in_wr;
    logic [DW-1:0] mem_rdata;

    dcf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk  (wr_clk_i),
        .we    (push),
        .waddr (waddr),
        .wdata (wr_data_i),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    dcf_wr_ctl #(.AW(AW)) u_wr (
        .clk         (wr_clk_i),
        .rst_n       (rst_ni),
        .wr_en_i     (wr_en_i),
        .rbin_sync_i (rbin_in_wr),
        .push_o      (push),
        .waddr_o     (waddr),
        .wgray_o     (wgray),
        .wr_rdy_o    (wr_rdy_o)
    );

    dcf_ptr_sync #(.W(PW)) u_sync_r2w (
        .clk    (wr_clk_i),
        .rst_n  (rst_ni),
        .gray_i (rgray),
        .bin_o  (rbin_in_wr)
    );

    dcf_ptr_sync #(.W(PW)) u_sync_w2r (
        .clk    (rd_clk_i),
        .rst_n  (rst_ni),
        .gray_i (wgray),
        .bin_o  (wbin_in_rd)
    );

    dcf_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
        .clk         (rd_clk_i),
        .rst_n       (rst_ni),
        .fwft_i      (fwft_i),
        .rd_en_i     (rd_en_i),
        .wbin_sync_i (wbin_in_rd),
        .mem_rdata_i (mem_rdata),
        .raddr_o     (raddr),
        .rgray_o     (rgray),
        .rd_data_o   (rd_data_o),
        .rd_flag_o   (rd_flag_o)
    );
endmodule

// File: tb/dual_clock_fifo_tb.sv
module dual_clock_fifo_tb;
    localparam int DEPTH = 16;
    localparam int DW    = 36;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_rdy;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_flag;

    int tests = 0;
    int fails = 0;
    int rcnt = 0;
    int wcnt = 0;
    int wbase = 0;
    int rbase = 0;
    logic [DW-1:0] refq[$];

    always #10 wclk = ~wclk;   // 50 MHz write clock, rising edges at even ns
    always #13 rclk = ~rclk;   // read clock, rising edges at odd ns

    always @(posedge rclk) rcnt <= rcnt + 1;
    always @(posedge wclk) wcnt <= wcnt + 1;
    always @(posedge wclk) if (wr_en) wbase <= rcnt;
    always @(posedge rclk) if (rd_en) rbase <= wcnt;

    dual_clock_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .wr_clk_i  (wclk),
        .rd_clk_i  (rclk),
        .rst_ni    (rst_n),
        .fwft_i    (fwft),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .wr_rdy_o  (wr_rdy),
        .rd_en_i   (rd_en),
        .rd_data_o (rd_data),
        .rd_flag_o (rd_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input bit mode);
        rst_n = 1'b0;
        fwft  = mode;
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (4) @(posedge rclk);
        @(negedge wclk) rst_n = 1'b1;
        @(negedge wclk);
    endtask

    task automatic write1(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge wclk);
        wr_en <= 1'b0;
    endtask

    task automatic read1();
        @(negedge rclk);
        rd_en = 1'b1;
        @(posedge rclk);
        rd_en <= 1'b0;
    endtask

    task automatic wait_rd(input int k);
        do @(negedge rclk); while (rcnt < wbase + k);
    endtask

    task automatic wait_wr(input int k);
        do @(negedge wclk); while (wcnt < rbase + k);
    endtask

    function automatic logic [DW-1:0] rand_word();
        return DW'({$urandom(), $urandom()});
    endfunction

    task automatic run_random(input bit mode, input int n);
        refq.delete();
        fork
            begin : writer
                int cnt = 0;
                while (cnt < n) begin
                    @(negedge wclk);
                    if (wr_rdy && ($urandom() % 100) < 60) begin
                        logic [DW-1:0] d = rand_word();
                        refq.push_back(d);
                        wr_en   = 1'b1;
                        wr_data = d;
                        cnt++;
                    end else begin
                        wr_en = 1'b0;
                    end
                end
                @(negedge wclk) wr_en = 1'b0;
            end
            begin : reader
                int got = 0;
                bit pend = 1'b0;
                logic [DW-1:0] exp = '0;
                while (got < n) begin
                    @(negedge rclk);
                    if (!mode) begin
                        if (pend) begin
                            chk(rd_data == exp, "R8 std order", rd_data, exp);
                            got++;
                            pend = 1'b0;
                        end
                        if (got < n && rd_flag && ($urandom() % 100) < 50) begin
                            rd_en = 1'b1;
                            exp   = refq.pop_front();
                            pend  = 1'b1;
                        end else begin
                            rd_en = 1'b0;
                        end
                    end else begin
                        if (rd_flag && ($urandom() % 100) < 50) begin
                            exp = refq.pop_front();
                            chk(rd_data == exp, "R8 fwft order", rd_data, exp);
                            got++;
                            rd_en = 1'b1;
                        end else begin
                            rd_en = 1'b0;
                        end
                    end
                end
                @(negedge rclk) rd_en = 1'b0;
            end
        join
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] fill [DEPTH];
        void'($urandom(32'h5eed_0001));

        // R1: reset state in standard mode
        do_reset(1'b0);
        chk(wr_rdy == 1'b1, "R1 wr_rdy after reset", wr_rdy, 1);
        chk(rd_flag == 1'b0, "R1 rd_flag after reset", rd_flag, 0);
        chk(rd_data == '0, "R1 rd_data after reset", rd_data, 0);

        // R9: request fall-through outside reset; standard timing must remain
        fwft = 1'b1;
        write1(36'hA_BCDE_0001);
        wait_rd(1);
        chk(rd_flag == 1'b0, "R2 flag low after edge 1", rd_flag, 0);
        wait_rd(2);
        chk(rd_flag == 1'b1, "R2 flag high after edge 2", rd_flag, 1);
        wait_rd(3);
        chk(rd_data == '0, "R9 no fall-through outside reset", rd_data, 0);
        fwft = 1'b0;

        // R3: read loads the word; read on empty leaves it
        read1();
        @(negedge rclk);
        chk(rd_data == 36'hA_BCDE_0001, "R3 read loads word", rd_data, 36'hA_BCDE_0001);
        chk(rd_flag == 1'b0, "R3 flag low once drained", rd_flag, 0);
        read1();
        @(negedge rclk);
        chk(rd_data == 36'hA_BCDE_0001, "R3 read on empty ignored", rd_data, 36'hA_BCDE_0001);

        // R6: fill the memory, then a refused write
        for (int i = 0; i < DEPTH; i++) begin
            fill[i] = 36'h1_0000_0100 + DW'(i);
            write1(fill[i]);
        end
        @(negedge wclk);
        chk(wr_rdy == 1'b0, "R6 wr_rdy low when full", wr_rdy, 0);
        write1(36'hD_EAD0_BEEF);
        @(negedge wclk);
        chk(wr_rdy == 1'b0, "R6 still full after refused write", wr_rdy, 0);

        // R7: release of the write flag two write edges after a read
        read1();
        wait_wr(1);
        chk(wr_rdy == 1'b0, "R7 wr_rdy low after write edge 1", wr_rdy, 0);
        wait_wr(2);
        chk(wr_rdy == 1'b1, "R7 wr_rdy high after write edge 2", wr_rdy, 1);
        chk(rd_data == fill[0], "R7 first word out", rd_data, fill[0]);
        for (int i = 1; i < DEPTH; i++) begin
            read1();
            @(negedge rclk);
            chk(rd_data == fill[i], "R6 drain order", rd_data, fill[i]);
        end
        repeat (4) @(negedge rclk);
        chk(rd_flag == 1'b0, "R6 refused word never stored", rd_flag, 0);

        // R4: fall-through latency
        do_reset(1'b1);
        chk(rd_flag == 1'b0, "R1 fwft flag after reset", rd_flag, 0);
        chk(wr_rdy == 1'b1, "R1 fwft wr_rdy after reset", wr_rdy, 1);
        write1(36'h3_3333_0C0C);
        wait_rd(2);
        chk(rd_flag == 1'b0, "R4 flag low after edge 2", rd_flag, 0);
        chk(rd_data == '0, "R4 data not yet moved", rd_data, 0);
        wait_rd(3);
        chk(rd_flag == 1'b1, "R4 flag high after edge 3", rd_flag, 1);
        chk(rd_data == 36'h3_3333_0C0C, "R4 word fell through", rd_data, 36'h3_3333_0C0C);

        // R5: hold, consume with refill, consume to empty, ignored read
        write1(36'h4_4444_0D0D);
        repeat (6) @(negedge rclk);
        chk(rd_data == 36'h3_3333_0C0C, "R5 word held without read", rd_data, 36'h3_3333_0C0C);
        read1();
        @(negedge rclk);
        chk(rd_data == 36'h4_4444_0D0D, "R5 next word on same edge", rd_data, 36'h4_4444_0D0D);
        chk(rd_flag == 1'b1, "R5 flag stays high", rd_flag, 1);
        read1();
        @(negedge rclk);
        chk(rd_flag == 1'b0, "R5 flag drops when empty", rd_flag, 0);
        read1();
        @(negedge rclk);
        chk(rd_data == 36'h4_4444_0D0D, "R5 read on low flag ignored", rd_data, 36'h4_4444_0D0D);
        chk(rd_flag == 1'b0, "R5 flag stays low", rd_flag, 0);

        // R8: random traffic in both modes
        run_random(1'b1, 300);
        do_reset(1'b0);
        run_random(1'b0, 300);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule